// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches one asynchronous serial line, apart from any frame decoder, and reports a break: a low level that lasts at least as long as one whole frame. It takes the already synchronized line, a per-line inversion select, the oversample tick that the receiver uses for timing, and the frame shape: how many data bits, whether a parity bit is present, and a stop length of none, half, one or one and a half bits. From these it works out a break threshold in oversample ticks.

Every falling edge of the effective line starts a fresh low-time measurement and captures the threshold for the current frame shape. The verdict comes only at the rising edge that ends the low period. If enough ticks were counted, the block raises a one-cycle break pulse. In the same cycle it raises a one-cycle request that tells the attached receiver to go back to waiting for a start bit. The measurement is then cleared until the next falling edge.

Top module: `uart_brk_detect`

## Requirements
- R1: `break_o` is a single-cycle pulse. It is high in the cycle that follows the clock edge at which the effective line is first sampled high after a qualifying low period.
- R2: The effective line is `line_i` XOR `inv_i`. A break is a low level of the effective line, so with `inv_i`=1 a long high level on `line_i` is a break.
- R3: A break is reported only if the number of counted ticks is at least the threshold. Exactly the threshold gives a pulse; one tick fewer gives none.
- R4: Threshold = ceil(H × OVS_TICKS / 2), where H = 2×(1 + D + P) + S. D is `data_bits_i` clamped to the range 5..9. P is 1 when `parity_en_i`=1. S comes from `stop_sel_i`: 0 = no stop bit, 1 = half bit, 2 = one bit, 3 = one and a half bits.
- R5: `rx_idle_o` pulses in exactly the same cycles as `break_o`.
- R6: The low-time count saturates at the threshold. A low period of any length, including one much longer than the counter range, gives exactly one pulse.
- R7: A rising edge gives no pulse if no falling edge has been recorded since reset. This includes a line that is already low when reset is released.
- R8: Each falling edge restarts the measurement from zero. Low periods separated by any high time are never summed.
- R9: The threshold is captured at the falling edge. Changing the frame configuration during a low period does not affect the verdict for that period.
- R10: A tick counts only when `tick_i` is high in a cycle strictly between the edge that samples the fall and the edge that samples the rise. Cycles without a tick add nothing.
- R11: While reset is active, and in the first cycle after it, `break_o` and `rx_idle_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Synchronized serial line |
| inv_i | input | 1 | Inverts the line before break detection |
| tick_i | input | 1 | Oversample tick, OVS_TICKS per bit time |
| data_bits_i | input | 4 | Data bit count, clamped to 5..9 |
| parity_en_i | input | 1 | A parity bit is part of the frame |
| stop_sel_i | input | 2 | Stop length: 0 none, 1 half, 2 one, 3 one and a half |
| break_o | output | 1 | One-cycle break pulse |
| rx_idle_o | output | 1 | One-cycle request for the receiver to return to waiting for a start bit |

## Verification
The hardest cases to reach from the ports are the ones where state from before the current low period could leak into the verdict. These are a line held low across reset release, a frame configuration changed in the middle of a low period, and a low level long enough to wrap an unsaturated counter. The stimulus holds the line low through reset and for hundreds of ticks after it. It switches the configuration to a longer frame shortly after a fall. It holds a low level for three thousand ticks, which would wrap the counter range many times over. Exact-threshold and threshold-minus-one runs are driven with sparse ticks as well as one tick per cycle, so that the verdict is shown to depend on counted ticks and not on elapsed cycles.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    localparam int unsigned MIN_DATA = 5;
    localparam int unsigned MAX_DATA = 9;
    // Largest frame length in half-bit units: start, 9 data, parity, 1.5 stop
    localparam int unsigned MAX_HALF = 2 * (1 + MAX_DATA + 1) + 3;

    typedef enum logic [1:0] {
        STOP_NONE     = 2'd0,
        STOP_HALF     = 2'd1,
        STOP_ONE      = 2'd2,
        STOP_ONE_HALF = 2'd3
    } stop_sel_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       parity_en;
        stop_sel_e  stop;
    } frame_cfg_t;

    typedef struct packed {
        logic level;   // effective line level
        logic fall;    // high-to-low seen this cycle
        logic rise;    // low-to-high seen this cycle
    } line_ev_t;

    // Frame length in half-bit units, with the data count clamped to 5..9
    function automatic int unsigned frame_halves(frame_cfg_t c);
        int unsigned d;
        if (32'(c.data_bits) < MIN_DATA)      d = MIN_DATA;
        else if (32'(c.data_bits) > MAX_DATA) d = MAX_DATA;
        else                                  d = 32'(c.data_bits);
        return 2 * (1 + d + (c.parity_en ? 1 : 0)) + 32'(c.stop);
    endfunction

endpackage

// File: rtl/uart_brk_thresh.sv
module uart_brk_thresh
    import uart_brk_pkg::*;
#(
    parameter int unsigned OVS_TICKS = 16,
    parameter int unsigned CNT_W     = 8
) (
    input  frame_cfg_t       cfg,
    output logic [CNT_W-1:0] thr
);
    int unsigned halves;

    always_comb halves = frame_halves(cfg);

    generate
        if (OVS_TICKS % 2 == 0) begin : g_even
            // Whole half-bit tick counts: no rounding needed
            localparam int unsigned HALF_TICKS = OVS_TICKS / 2;
            always_comb thr = CNT_W'(halves * HALF_TICKS);
        end else begin : g_odd
            // Odd oversampling: round the half-bit product up
            always_comb thr = CNT_W'((halves * OVS_TICKS + 1) / 2);
        end
    endgenerate

endmodule

// File: rtl/uart_brk_edge.sv
module uart_brk_edge
    import uart_brk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    input  logic     inv_i,
    output line_ev_t ev
);
    logic eff;
    logic prev_q;
    logic seen_q;   // one sample taken since reset, edges valid

    always_comb eff = line_i ^ inv_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            seen_q <= 1'b0;
        end else begin
            prev_q <= eff;
            seen_q <= 1'b1;
        end
    end

    always_comb begin
        ev.level = eff;
        ev.fall  = seen_q &  prev_q & ~eff;
        ev.rise  = seen_q & ~prev_q &  eff;
    end

endmodule

// File: rtl/uart_brk_timer.sv
module uart_brk_timer
    import uart_brk_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             brk_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] thr_o,
    output logic             armed_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic             armed_q;
    logic             brk_q;
    logic             can_count;

    always_comb can_count = armed_q & ~ev.level & tick_i & (cnt_q < thr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            thr_q   <= '0;
            armed_q <= 1'b0;
            brk_q   <= 1'b0;
        end else begin
            brk_q <= 1'b0;
            if (ev.fall) begin
                cnt_q   <= '0;
                thr_q   <= thr_i;
                armed_q <= 1'b1;
            end else if (ev.rise) begin
                brk_q   <= armed_q & (cnt_q >= thr_q);
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else if (can_count) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign brk_o   = brk_q;
    assign cnt_o   = cnt_q;
    assign thr_o   = thr_q;
    assign armed_o = armed_q;

endmodule

// File: rtl/uart_brk_detect.sv
module uart_brk_detect
    import uart_brk_pkg::*;
#(
    parameter int unsigned OVS_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    input  logic       inv_i,
    input  logic       tick_i,
    input  logic [3:0] data_bits_i,
    input  logic       parity_en_i,
    input  logic [1:0] stop_sel_i,
    output logic       break_o,
    output logic       rx_idle_o
);
    localparam int unsigned MAX_THR = (MAX_HALF * OVS_TICKS + 1) / 2;
    localparam int unsigned CNT_W   = $clog2(MAX_THR + 1);

    frame_cfg_t       cfg;
    line_ev_t         ev;
    logic [CNT_W-1:0] thr_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] thr_lat_w;
    logic             armed_w;
    logic             brk_w;

    always_comb begin
        cfg.data_bits = data_bits_i;
        cfg.parity_en = parity_en_i;
        cfg.stop      = stop_sel_e'(stop_sel_i);
    end

    uart_brk_thresh #(.OVS_TICKS(OVS_TICKS), .CNT_W(CNT_W)) u_thresh (
        .cfg (cfg),
        .thr (thr_w)
    );

    uart_brk_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .inv_i  (inv_i),
        .ev     (ev)
    );

    uart_brk_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .tick_i  (tick_i),
        .thr_i   (thr_w),
        .brk_o   (brk_w),
        .cnt_o   (cnt_w),
        .thr_o   (thr_lat_w),
        .armed_o (armed_w)
    );

    assign break_o   = brk_w;
    assign rx_idle_o = brk_w;

endmodule

// File: rtl/uart_brk_detect_chk.sv
module uart_brk_detect_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             line_i,
    input logic             inv_i,
    input logic             break_o,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thr_q,
    input logic             armed
);
    logic eff;
    logic up_q;

    always_comb eff = line_i ^ inv_i;

    always_ff @(posedge clk) begin
        if (rst) up_q <= 1'b0;
        else     up_q <= 1'b1;
    end

    // R1: pulse lasts one cycle
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        break_o |=> !break_o);

    // R2: pulse follows a low-to-high change of the effective line
    p_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
        break_o |-> ($past(eff) && !$past(eff, 2)));

    // R3: enough ticks were counted
    p_enough_ticks_r3: assert property (@(posedge clk) disable iff (rst)
        break_o |-> ($past(cnt) >= $past(thr_q)));

    // R6: count never passes its captured threshold
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= thr_q);

    // R7: pulse only when a fall was recorded
    p_armed_before_r7: assert property (@(posedge clk) disable iff (rst)
        break_o |-> $past(armed));

    // R8: a fall restarts the measurement
    p_fall_restarts_r8: assert property (@(posedge clk) disable iff (rst)
        (up_q && $fell(eff)) |=> (armed && cnt == '0));

endmodule

bind uart_brk_detect uart_brk_detect_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_i),
    .inv_i   (inv_i),
    .break_o (break_o),
    .cnt     (cnt_w),
    .thr_q   (thr_lat_w),
    .armed   (armed_w)
);

// File: tb/tb_uart_brk_detect.sv
`timescale 1ns/1ps
module tb_uart_brk_detect;

    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_r = 1'b1;
    logic       inv_r = 1'b0;
    logic       tick_r = 1'b0;
    logic [3:0] db_r = 4'd8;
    logic       par_r = 1'b0;
    logic [1:0] stop_r = 2'd2;
    logic       break_o, rx_idle_o;

    int tests = 0;
    int fails = 0;
    int brk_seen = 0;
    int idle_seen = 0;
    int mism = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_brk_detect #(.OVS_TICKS(OVS)) dut (
        .clk(clk), .rst(rst), .line_i(line_r), .inv_i(inv_r), .tick_i(tick_r),
        .data_bits_i(db_r), .parity_en_i(par_r), .stop_sel_i(stop_r),
        .break_o(break_o), .rx_idle_o(rx_idle_o)
    );

    function automatic int thr_of(int db, int par, int st);
        int d;
        d = (db < 5) ? 5 : (db > 9) ? 9 : db;
        return ((2 * (1 + d + par) + st) * OVS + 1) / 2;
    endfunction

    // Behavioural reference, evaluated on every rising edge
    bit m_prev = 1, m_seen = 0, m_armed = 0, m_exp = 0;
    int m_cnt = 0, m_thr = 0;
    always @(posedge clk) begin
        bit e;
        e = line_r ^ inv_r;
        if (rst) begin
            m_prev = 1; m_seen = 0; m_armed = 0; m_cnt = 0; m_thr = 0; m_exp = 0;
        end else begin
            m_exp = 0;
            if (!m_seen) m_seen = 1;
            else if (m_prev && !e) begin
                m_armed = 1; m_cnt = 0; m_thr = thr_of(int'(db_r), int'(par_r), int'(stop_r));
            end else if (!m_prev && e) begin
                m_exp = m_armed && (m_cnt >= m_thr);
                m_armed = 0; m_cnt = 0;
            end else if (m_armed && !e && tick_r && m_cnt < m_thr) m_cnt++;
            m_prev = e;
        end
    end

    always @(negedge clk) begin
        if (break_o !== m_exp || rx_idle_o !== m_exp) begin
            mism++;
            if (mism < 5)
                $display("[TB] MISMATCH t=%0t break=%b idle=%b model=%b", $time, break_o, rx_idle_o, m_exp);
        end
        if (!rst && break_o)   brk_seen++;
        if (!rst && rx_idle_o) idle_seen++;
    end

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(int db, int par, int st);
        @(negedge clk);
        db_r = 4'(db); par_r = 1'(par); stop_r = 2'(st);
    endtask

    // One low period with nt counted ticks, one every gap cycles
    task automatic low_run(int nt, int gap);
        @(negedge clk); line_r = inv_r; tick_r = 0;
        for (int i = 0; i < nt; i++)
            for (int j = 0; j < gap; j++) begin
                @(negedge clk); tick_r = (j == gap - 1);
            end
        @(negedge clk); line_r = ~inv_r; tick_r = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_run(string req, int nt, int gap, int exp_n);
        int b;
        b = brk_seen;
        low_run(nt, gap);
        check((brk_seen - b) == exp_n, req, brk_seen - b, exp_n);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        int b, ib, t;
        repeat (3) @(negedge clk);
        check(break_o == 0 && rx_idle_o == 0, "R11 reset outputs", int'(break_o), 0);
        rst = 0;
        @(negedge clk);
        check(break_o == 0 && rx_idle_o == 0, "R11 after release", int'(break_o), 0);
        repeat (3) @(negedge clk);

        // 8 data, no parity, 1 stop
        set_cfg(8, 0, 2);
        t = thr_of(8, 0, 2);
        check(t == 160, "R4 8N1 threshold", t, 160);
        ib = idle_seen;
        expect_run("R3 exact threshold 8N1", t, 1, 1);
        check(idle_seen - ib == 1, "R5 idle request with break", idle_seen - ib, 1);
        expect_run("R3 threshold-1 8N1", t - 1, 1, 0);

        // 5 data, parity, half stop
        set_cfg(5, 1, 1);
        t = thr_of(5, 1, 1);
        expect_run("R4 half stop exact", t, 1, 1);
        expect_run("R4 half stop minus one", t - 1, 1, 0);

        // 9 data, 1.5 stop
        set_cfg(9, 0, 3);
        t = thr_of(9, 0, 3);
        expect_run("R4 1.5 stop exact", t, 1, 1);
        expect_run("R4 1.5 stop minus one", t - 1, 1, 0);

        // no stop bit
        set_cfg(8, 0, 0);
        t = thr_of(8, 0, 0);
        expect_run("R4 zero stop exact", t, 1, 1);
        expect_run("R4 zero stop minus one", t - 1, 1, 0);

        // clamping of data count
        set_cfg(2, 0, 2);
        t = thr_of(5, 0, 2);
        expect_run("R4 clamp low exact", t, 1, 1);
        expect_run("R4 clamp low minus one", t - 1, 1, 0);
        set_cfg(15, 1, 2);
        t = thr_of(9, 1, 2);
        expect_run("R4 clamp high minus one", t - 1, 1, 0);
        expect_run("R4 clamp high exact", t, 1, 1);

        // sparse ticks
        set_cfg(8, 0, 2);
        t = thr_of(8, 0, 2);
        expect_run("R10 sparse ticks exact", t, 4, 1);
        expect_run("R10 sparse ticks minus one", t - 1, 3, 0);

        // inverted line
        @(negedge clk); inv_r = 1; line_r = 1'b0;
        repeat (3) @(negedge clk);
        expect_run("R2 inverted exact", t, 1, 1);
        expect_run("R2 inverted minus one", t - 1, 1, 0);
        @(negedge clk); inv_r = 0; line_r = 1'b1;
        repeat (3) @(negedge clk);

        // restart on each fall
        b = brk_seen;
        low_run(100, 1);
        low_run(100, 1);
        check(brk_seen == b, "R8 split low periods", brk_seen - b, 0);

        // very long low period
        expect_run("R6 long break single pulse", 3000, 1, 1);

        // config changed mid low period
        set_cfg(5, 0, 2);
        b = brk_seen;
        @(negedge clk); line_r = 0; tick_r = 0;
        @(negedge clk); db_r = 4'd9; par_r = 1; stop_r = 2'd3; tick_r = 1;
        repeat (thr_of(5, 0, 2) + 2) @(negedge clk);
        line_r = 1; tick_r = 0;
        repeat (4) @(negedge clk);
        check(brk_seen - b == 1, "R9 threshold captured at fall", brk_seen - b, 1);
        set_cfg(8, 0, 2);

        // low at reset release
        @(negedge clk); line_r = 0;
        do_reset();
        b = brk_seen;
        tick_r = 1;
        repeat (400) @(negedge clk);
        line_r = 1; tick_r = 0;
        repeat (4) @(negedge clk);
        check(brk_seen == b, "R7 no fall since reset", brk_seen - b, 0);
        expect_run("R7 normal after reset", thr_of(8, 0, 2), 1, 1);

        check(mism == 0, "R1 R5 per-cycle model agreement", mism, 0);
        check(brk_seen == idle_seen, "R5 totals equal", idle_seen, brk_seen);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("[TB] FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule